// File: doc/BRIEF.md
# Double-Edge Write Data Capture with Byte Masks

This block receives write data from a 16-bit double-data-rate bus. Each byte lane has its own strobe and its own mask bit. While a write window is open, a lane stores its data byte and mask bit on every rising edge of its strobe, and again on every falling edge. A rising-edge beat and the falling-edge beat that follows it form one pair. Each lane writes the pair into a small buffer that lives in the strobe's clock domain.

The core clock domain receives each lane's write pointer, Gray coded, through two synchronising flops. It takes a pair out of the buffers once every lane holds one. It then presents a 32-bit word with four byte-write enables to a downstream memory array for one cycle.

A configuration input sets the burst length to 2, 4 or 8 beats. A one-cycle done pulse follows the word that completes the burst. The strobes are modelled as ideal edges centred on the data.

Top module: `ddr_wr_capture`

## Requirements
- R1: Each output word carries a rising-edge beat in `word_data[15:0]` and the falling-edge beat that follows it in `word_data[31:16]`.
- R2: Lane 0 (`byte_strobe[0]`, `mask_in[0]`) captures `data_in[7:0]` into word bytes 0 and 2. Lane 1 (`byte_strobe[1]`, `mask_in[1]`) captures `data_in[15:8]` into word bytes 1 and 3. Each lane is clocked only by its own strobe, so the two strobes may be skewed against each other.
- R3: `word_be` bit k is low exactly when the mask bit sampled with word byte k was high. Bit 0 is lane 0 rise, bit 1 is lane 1 rise, bit 2 is lane 0 fall, bit 3 is lane 1 fall. A masked byte still appears in `word_data`.
- R4: A strobe rising edge seen while `wr_window` is low captures nothing. The falling edge after it writes nothing into the buffer, and no word results.
- R5: `burst_sel` encodes the burst length as 00 = 2 beats, 01 = 4 beats, and 10 or 11 = 8 beats. A burst yields half that many words.
- R6: `burst_done` is high for one cycle, in the cycle after the `word_valid` of the last word of a burst, and at no other time.
- R7: While `rst_n` is low, and in the first cycles after it is released, `word_valid` and `burst_done` are low.
- R8: Bursts sent back to back come out in order, with no word lost or repeated, and the buffer never holds more than its depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_sel | input | 2 | Burst length select, held steady during a burst |
| wr_window | input | 1 | High while a write burst is on the bus |
| byte_strobe | input | 2 | Per-lane data strobe, used as the capture clock |
| data_in | input | 16 | Double-data-rate write data |
| mask_in | input | 2 | Per-lane write mask, sampled on both strobe edges |
| word_valid | output | 1 | One-cycle qualifier for `word_data` and `word_be` |
| word_data | output | 32 | Rise beat in the low half, fall beat in the high half |
| word_be | output | 4 | Active-high byte-write enables |
| burst_done | output | 1 | Pulse marking the end of a burst |

## Verification
The bench builds the block with its default values: two lanes and a two-entry buffer. At that size, sixteen bursts at each burst length sweep every one of the sixteen mask combinations of a pair, in every word position of every burst length. The upper strobe runs a fixed skew behind the lower one, so each lane captures on its own strobe. The done pulse is checked against a word count kept in the bench. A window-closed run of strobe edges, placed between bursts, shows that stray edges leave no mark.

// File: rtl/ddrw_pkg.sv
package ddrw_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    BURST_2   = 2'b00,
    BURST_4   = 2'b01,
    BURST_8   = 2'b10,
    BURST_8_B = 2'b11
  } burst_sel_e;

  // one lane's share of a rise/fall pair
  typedef struct packed {
    logic              fall_m;
    logic [BYTE_W-1:0] fall_d;
    logic              rise_m;
    logic [BYTE_W-1:0] rise_d;
  } lane_pair_t;

endpackage

// File: rtl/ddrw_lane_cap.sv
module ddrw_lane_cap
  import ddrw_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic                       rst_n,
  input  logic                       strobe,
  input  logic                       win,
  input  logic [BYTE_W-1:0]          dq,
  input  logic                       dm,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx,
  output logic [$clog2(DEPTH):0]     wptr_gray,
  output lane_pair_t                 rd_pair
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;

  logic [BYTE_W-1:0] rise_d;
  logic              rise_m;
  logic              armed;
  logic [PTR_W-1:0]  wbin, wbin_nxt, wgray_nxt;
  lane_pair_t        slot;
  lane_pair_t        mem [DEPTH];

  // rising edge: hold the first beat of a pair
  always_ff @(posedge strobe or negedge rst_n) begin
    if (!rst_n) begin
      rise_d <= '0;
      rise_m <= 1'b0;
      armed  <= 1'b0;
    end else begin
      armed <= win;
      if (win) begin
        rise_d <= dq;
        rise_m <= dm;
      end
    end
  end

  always_comb begin
    wbin_nxt    = wbin + 1'b1;
    wgray_nxt   = wbin_nxt ^ (wbin_nxt >> 1);
    slot.fall_d = dq;
    slot.fall_m = dm;
    slot.rise_d = rise_d;
    slot.rise_m = rise_m;
  end

  // falling edge: complete the pair and push it
  always_ff @(negedge strobe or negedge rst_n) begin
    if (!rst_n) begin
      wbin      <= '0;
      wptr_gray <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (armed) begin
      wbin              <= wbin_nxt;
      wptr_gray         <= wgray_nxt;
      mem[wbin[IDX_W-1:0]] <= slot;
    end
  end

  assign rd_pair = mem[rd_idx];

endmodule

// File: rtl/ddrw_ptr_sync.sv
module ddrw_ptr_sync #(
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] gray_in,
  output logic [PTR_W-1:0] bin_out
);

  logic [PTR_W-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  always_comb begin
    for (int i = 0; i < PTR_W; i++) bin_out[i] = ^(stage2 >> i);
  end

  // R8
  gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stage2 ^ $past(stage2)) <= 1);

endmodule

// File: rtl/ddrw_drain.sv
module ddrw_drain
  import ddrw_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int DEPTH     = 2,
  parameter int MAX_BEATS = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [1:0]                          burst_sel,
  input  logic [LANES-1:0][$clog2(DEPTH):0]   lane_wbin,
  input  lane_pair_t [LANES-1:0]              lane_pair,
  output logic [$clog2(DEPTH)-1:0]            rd_idx,
  output logic                                word_valid,
  output logic [2*LANES*BYTE_W-1:0]           word_data,
  output logic [2*LANES-1:0]                  word_be,
  output logic                                burst_done
);

  localparam int IDX_W   = $clog2(DEPTH);
  localparam int PTR_W   = IDX_W + 1;
  localparam int HALF_W  = LANES * BYTE_W;
  localparam int CNT_W   = $clog2(MAX_BEATS / 2) + 1;

  logic [PTR_W-1:0]          rd_ptr, rd_ptr_nxt;
  logic [CNT_W-1:0]          cnt, cnt_nxt, tgt;
  logic                      pop, last, last_q;
  logic [LANES-1:0]          has_data;
  logic [2*HALF_W-1:0]       data_nxt;
  logic [2*LANES-1:0]        be_nxt;

  always_comb begin
    unique case (burst_sel_e'(burst_sel))
      BURST_2: tgt = CNT_W'(1);
      BURST_4: tgt = CNT_W'(2);
      default: tgt = CNT_W'(MAX_BEATS / 2);
    endcase
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      has_data[l] = (lane_wbin[l] != rd_ptr);
      data_nxt[l*BYTE_W +: BYTE_W]          = lane_pair[l].rise_d;
      data_nxt[HALF_W + l*BYTE_W +: BYTE_W] = lane_pair[l].fall_d;
      be_nxt[l]         = ~lane_pair[l].rise_m;
      be_nxt[LANES + l] = ~lane_pair[l].fall_m;
    end
    pop        = &has_data;
    last       = pop && (cnt == tgt - 1'b1);
    rd_ptr_nxt = rd_ptr + 1'b1;
    cnt_nxt    = last ? '0 : cnt + 1'b1;
  end

  assign rd_idx = rd_ptr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr     <= '0;
      cnt        <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
      word_be    <= '0;
      last_q     <= 1'b0;
      burst_done <= 1'b0;
    end else begin
      word_valid <= pop;
      last_q     <= last;
      burst_done <= last_q;
      if (pop) begin
        rd_ptr    <= rd_ptr_nxt;
        cnt       <= cnt_nxt;
        word_data <= data_nxt;
        word_be   <= be_nxt;
      end
    end
  end

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_occ
      // R8
      no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (PTR_W'(lane_wbin[l] - rd_ptr)) <= PTR_W'(DEPTH));
    end
  endgenerate

  // R5
  burst_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < tgt);

  // R6
  done_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> $past(word_valid));

endmodule

// File: rtl/ddr_wr_capture.sv
module ddr_wr_capture
  import ddrw_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int DEPTH     = 2,
  parameter int MAX_BEATS = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   burst_sel,
  input  logic                         wr_window,
  input  logic [LANES-1:0]             byte_strobe,
  input  logic [LANES*BYTE_W-1:0]      data_in,
  input  logic [LANES-1:0]             mask_in,
  output logic                         word_valid,
  output logic [2*LANES*BYTE_W-1:0]    word_data,
  output logic [2*LANES-1:0]           word_be,
  output logic                         burst_done
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;

  logic                          rst_meta, core_rst_n;
  logic [LANES-1:0][PTR_W-1:0]   lane_gray, lane_wbin;
  lane_pair_t [LANES-1:0]        lane_pair;
  logic [IDX_W-1:0]              rd_idx;

  // reset asserts at once, releases on the core clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      core_rst_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      core_rst_n <= rst_meta;
    end
  end

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      ddrw_lane_cap #(.DEPTH(DEPTH)) u_cap (
        .rst_n     (rst_n),
        .strobe    (byte_strobe[l]),
        .win       (wr_window),
        .dq        (data_in[l*BYTE_W +: BYTE_W]),
        .dm        (mask_in[l]),
        .rd_idx    (rd_idx),
        .wptr_gray (lane_gray[l]),
        .rd_pair   (lane_pair[l])
      );

      ddrw_ptr_sync #(.PTR_W(PTR_W)) u_sync (
        .clk     (clk),
        .rst_n   (core_rst_n),
        .gray_in (lane_gray[l]),
        .bin_out (lane_wbin[l])
      );
    end
  endgenerate

  ddrw_drain #(
    .LANES     (LANES),
    .DEPTH     (DEPTH),
    .MAX_BEATS (MAX_BEATS)
  ) u_drain (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .burst_sel  (burst_sel),
    .lane_wbin  (lane_wbin),
    .lane_pair  (lane_pair),
    .rd_idx     (rd_idx),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_be    (word_be),
    .burst_done (burst_done)
  );

endmodule

// File: tb/ddr_wr_capture_tb.sv
`timescale 1ns/1ps
module ddr_wr_capture_tb;

  logic        clk;
  logic        rst_n;
  logic [1:0]  burst_sel;
  logic        wr_window;
  logic [1:0]  byte_strobe;
  logic [15:0] data_in;
  logic [1:0]  mask_in;
  logic        word_valid;
  logic [31:0] word_data;
  logic [3:0]  word_be;
  logic        burst_done;

  ddr_wr_capture u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .burst_sel   (burst_sel),
    .wr_window   (wr_window),
    .byte_strobe (byte_strobe),
    .data_in     (data_in),
    .mask_in     (mask_in),
    .word_valid  (word_valid),
    .word_data   (word_data),
    .word_be     (word_be),
    .burst_done  (burst_done)
  );

  int vectors = 0;
  int miscmp  = 0;
  int cyc     = 0;
  int exp_n   = 0;
  int got_n   = 0;
  int cur_pairs = 1;
  int pair_pos  = 0;
  bit mon_en    = 0;
  bit done_due  = 0;
  logic [31:0] exp_data [0:255];
  logic [3:0]  exp_be   [0:255];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      miscmp++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      summary();
    end
  end

  function automatic logic [15:0] pat(input int s, input int b);
    return {8'(s * 37 + b * 11 + 1), 8'(s * 91 + b * 13 + 7)};
  endfunction

  // monitor: compares words and the done pulse in the middle of each cycle
  always @(negedge clk) begin
    if (mon_en) begin
      if (done_due || burst_done)
        check("R6 R5 done pulse", 32'(burst_done), 32'(done_due));
      done_due = 1'b0;
      if (word_valid) begin
        if (got_n >= exp_n) begin
          vectors++;
          miscmp++;
          $display("FAIL R4 R8 unexpected word actual=%h expected=none", word_data);
        end else begin
          check("R1 R2 low half rise beat", 32'(word_data[15:0]), 32'(exp_data[got_n][15:0]));
          check("R1 R2 high half fall beat", 32'(word_data[31:16]), 32'(exp_data[got_n][31:16]));
          check("R3 byte enables", 32'(word_be), 32'(exp_be[got_n]));
        end
        got_n++;
        pair_pos++;
        if (pair_pos == cur_pairs) begin
          pair_pos = 0;
          done_due = 1'b1;
        end
      end
    end
  end

  task automatic drive_beat(input logic [15:0] d, input logic [1:0] m);
    data_in = d;
    mask_in = m;
    #8 byte_strobe[0] = ~byte_strobe[0];
    #2 byte_strobe[1] = ~byte_strobe[1];
    #10;
  endtask

  task automatic send_burst(input int sel, input int seed);
    int pairs;
    int base;
    pairs     = (2 << sel) / 2;
    burst_sel = 2'(sel);
    cur_pairs = pairs;
    base      = exp_n;
    for (int p = 0; p < pairs; p++) begin
      logic [3:0] combo;
      combo = 4'((seed + p * 5) & 15);
      exp_data[exp_n] = {pat(seed, 2 * p + 1), pat(seed, 2 * p)};
      exp_be[exp_n]   = ~combo;
      exp_n++;
    end
    wr_window = 1'b1;
    #2;
    for (int p = 0; p < pairs; p++) begin
      logic [3:0] combo;
      combo = 4'((seed + p * 5) & 15);
      drive_beat(pat(seed, 2 * p), combo[1:0]);
      drive_beat(pat(seed, 2 * p + 1), combo[3:2]);
    end
    wr_window = 1'b0;
    #120;
    check("R5 R8 words delivered", 32'(got_n), 32'(base + pairs));
  endtask

  initial begin
    rst_n       = 1'b0;
    burst_sel   = 2'b00;
    wr_window   = 1'b0;
    byte_strobe = 2'b00;
    data_in     = '0;
    mask_in     = '0;
    #23;
    check("R7 valid in reset", 32'(word_valid), 32'd0);
    check("R7 done in reset", 32'(burst_done), 32'd0);
    rst_n = 1'b1;
    #31;
    check("R7 valid after release", 32'(word_valid), 32'd0);
    check("R7 done after release", 32'(burst_done), 32'd0);
    mon_en = 1'b1;

    for (int sel = 0; sel < 3; sel++) begin
      for (int seed = 0; seed < 16; seed++) send_burst(sel, seed);
      // R4: strobe edges with the window closed
      for (int b = 0; b < 4; b++) drive_beat(16'hA5C3 ^ 16'(b), 2'b00);
      #120;
      check("R4 no word outside window", 32'(got_n), 32'(exp_n));
    end

    // 11 decodes as the 8-beat length (R5)
    send_burst(2, 3);
    burst_sel = 2'b11;
    cur_pairs = 4;
    for (int p = 0; p < 4; p++) begin
      exp_data[exp_n] = {pat(7, 2 * p + 1), pat(7, 2 * p)};
      exp_be[exp_n]   = 4'hF;
      exp_n++;
    end
    wr_window = 1'b1;
    #2;
    for (int b = 0; b < 8; b++) drive_beat(pat(7, b), 2'b00);
    wr_window = 1'b0;
    #120;
    check("R5 code 11 burst words", 32'(got_n), 32'(exp_n));
    check("R8 final word count", 32'(got_n), 32'(exp_n));
    summary();
  end

endmodule